// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block sits between an 8-bit host bus and two 12-bit digital-to-analog converter channels. The host sees it as a small memory-mapped peripheral. A 2-bit select input, driven by the two lowest address lines, picks one of four staging registers: the lower byte or the upper nibble of channel A or of channel B. The host fills a channel's 12-bit code with two byte writes, qualified by an active-low chip select and an active-low write strobe. The data is right-justified.

Staged values do not reach the converter outputs at once. A separate active-low load strobe is shared by both channels. Its rising edge copies both staging registers into the output registers in one clock cycle, so both converters change together. The host therefore sees five actions in all: four staging writes and one load.

All bus strobes are asynchronous to the block clock. They pass through a synchronizer of configurable depth. Each action is recognised at the rising edge of its synchronized strobe, using the bus values sampled while the strobe was still low. An asynchronous reset clears every staging and output register.

Top module: `dual_dac_regif`

## Requirements
- R1: While reset is asserted, and right after it, both output codes read zero.
- R2: A lower-byte write stores all 8 data bits into bits 7:0 of the selected channel's staging code.
- R3: An upper-byte write stores data bits 3:0 into bits 11:8 of the selected channel's staging code. Data bits 7:4 are discarded.
- R4: The select value chooses the target register: 00 is channel A low, 01 is channel A high, 10 is channel B low and 11 is channel B high. No other staging register changes.
- R5: A write strobe that rises while chip select is high (inactive) changes no staging register.
- R6: A staging write never changes either output code by itself.
- R7: A rising edge on the load strobe copies both channels' staging codes to both outputs in the same clock cycle. Chip select does not gate the load.
- R8: If a load edge and a staging write edge are recognised in the same cycle, the load transfers the staging contents from before that write. The write still lands in staging.
- R9: A load with no writes since the previous load leaves both outputs unchanged.
- R10: The asynchronous reset also clears the staging registers. A load straight after reset yields zero on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the action happens on its rising edge |
| load_n | input | 1 | Active-low common load strobe; the action happens on its rising edge |
| sel | input | 2 | Staging register select, driven by the low address lines |
| data | input | BUS_W (8) | Host write data |
| code_a | output | CODE_W (12) | Channel A output code |
| code_b | output | CODE_W (12) | Channel B output code |

## Verification
A fault in the staging registers stays hidden until the next load strobe. At that point both output codes show it, a fixed number of synchronizer cycles after the load edge. For this reason the bench pairs every batch of random writes with a load and compares both channels against its own model. A fault in the output registers or in the load path shows at once, as an output that changes without a load or that misses the transfer. The same-cycle load-and-write case and the ignored write without chip select are directed, because random stimulus reaches them rarely.

// File: rtl/dac_regif_pkg.sv
`timescale 1ns/1ps
package dac_regif_pkg;

  // Staging register select values, taken from the low host address lines
  typedef enum logic [1:0] {
    SEL_A_LO = 2'b00,
    SEL_A_HI = 2'b01,
    SEL_B_LO = 2'b10,
    SEL_B_HI = 2'b11
  } stage_sel_e;

  // Bus strobes, all active low
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};

endpackage

// File: rtl/dac_bus_sync.sv
`timescale 1ns/1ps
module dac_bus_sync
  import dac_regif_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int SEL_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             load_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [BUS_W-1:0] data,
  output logic             wr_evt,
  output logic             load_evt,
  output logic [SEL_W-1:0] sel_q,
  output logic [BUS_W-1:0] data_q
);

  localparam int PW    = SEL_W + BUS_W;
  localparam int DEPTH = STAGES + 1;

  strobe_t          s_pipe [DEPTH];
  logic [PW-1:0]    d_pipe [DEPTH];
  strobe_t          s_new, s_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pipe[0] <= STROBE_IDLE;
      d_pipe[0] <= '0;
    end else begin
      s_pipe[0] <= '{cs_n: cs_n, wr_n: wr_n, ld_n: load_n};
      d_pipe[0] <= {sel, data};
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_pipe[i] <= STROBE_IDLE;
        d_pipe[i] <= '0;
      end else begin
        s_pipe[i] <= s_pipe[i-1];
        d_pipe[i] <= d_pipe[i-1];
      end
    end
  end

  assign s_new = s_pipe[DEPTH-2];
  assign s_old = s_pipe[DEPTH-1];

  // The bus values come from the sample taken while the strobe was still low
  assign wr_evt   = !s_old.wr_n && s_new.wr_n && !s_old.cs_n;
  assign load_evt = !s_old.ld_n && s_new.ld_n;
  assign {sel_q, data_q} = d_pipe[DEPTH-1];

  // R7: a load edge yields exactly one single-cycle event
  p_single_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);

endmodule

// File: rtl/dac_stage_bank.sv
`timescale 1ns/1ps
module dac_stage_bank
  import dac_regif_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8,
  parameter int NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_evt,
  input  logic [1:0]                 sel,
  input  logic [BUS_W-1:0]           data,
  output logic [NCH-1:0][CODE_W-1:0] staged
);

  localparam int HI_W = CODE_W - BUS_W;

  function automatic logic [CODE_W-1:0] put_low(input logic [CODE_W-1:0] cur,
                                                input logic [BUS_W-1:0]  b);
    return {cur[CODE_W-1:BUS_W], b};
  endfunction

  function automatic logic [CODE_W-1:0] put_high(input logic [CODE_W-1:0] cur,
                                                 input logic [HI_W-1:0]   nib);
    return {nib, cur[BUS_W-1:0]};
  endfunction

  logic [NCH-1:0] hit_lo, hit_hi;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [1:0] LO_SEL = 2'(2 * ch);
    localparam logic [1:0] HI_SEL = 2'(2 * ch + 1);

    assign hit_lo[ch] = wr_evt && (sel == LO_SEL);
    assign hit_hi[ch] = wr_evt && (sel == HI_SEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          staged[ch] <= '0;
      else if (hit_lo[ch]) staged[ch] <= put_low(staged[ch], data);
      else if (hit_hi[ch]) staged[ch] <= put_high(staged[ch], data[HI_W-1:0]);
    end

    // R2: lower write captures the full data byte
    p_low_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lo[ch] |=> staged[ch][BUS_W-1:0] == $past(data));

    // R3: upper write captures only the low nibble into the top bits
    p_high_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_hi[ch] |=> staged[ch][CODE_W-1:BUS_W] == $past(data[HI_W-1:0]));

    // R4: upper write leaves the lower byte of the same channel alone
    p_high_keeps_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_hi[ch] |=> staged[ch][BUS_W-1:0] == $past(staged[ch][BUS_W-1:0]));
  end

  // R5: no recognised write, no staging change
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> staged == $past(staged));

endmodule

// File: rtl/dac_output_stage.sv
`timescale 1ns/1ps
module dac_output_stage #(
  parameter int CODE_W = 12,
  parameter int NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_evt,
  input  logic [NCH-1:0][CODE_W-1:0] staged,
  output logic [NCH-1:0][CODE_W-1:0] codes
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        codes[ch] <= '0;
      else if (load_evt) codes[ch] <= staged[ch];
    end
  end

  // R6: outputs move only on a load
  p_hold_without_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> codes == $past(codes));

  // R7 / R8: a load takes the staging value present in its own cycle
  p_load_transfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> codes == $past(staged));

endmodule

// File: rtl/dual_dac_regif.sv
`timescale 1ns/1ps
module dual_dac_regif
  import dac_regif_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              load_n,
  input  logic [1:0]        sel,
  input  logic [BUS_W-1:0]  data,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);

  localparam int NCH   = 2;
  localparam int SEL_W = 2;

  logic                       wr_evt, load_evt;
  logic [SEL_W-1:0]           sel_q;
  logic [BUS_W-1:0]           data_q;
  logic [NCH-1:0][CODE_W-1:0] staged;
  logic [NCH-1:0][CODE_W-1:0] codes;

  dac_bus_sync #(.BUS_W(BUS_W), .SEL_W(SEL_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .load_n(load_n),
    .sel(sel), .data(data), .wr_evt(wr_evt), .load_evt(load_evt),
    .sel_q(sel_q), .data_q(data_q)
  );

  dac_stage_bank #(.CODE_W(CODE_W), .BUS_W(BUS_W), .NCH(NCH)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .sel(sel_q), .data(data_q),
    .staged(staged)
  );

  dac_output_stage #(.CODE_W(CODE_W), .NCH(NCH)) i_out (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .staged(staged),
    .codes(codes)
  );

  assign code_a = codes[0];
  assign code_b = codes[1];

  // R4: writes aimed at channel A never touch channel B staging, and back
  p_a_write_spares_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && (sel_q == SEL_A_LO || sel_q == SEL_A_HI) |=> staged[1] == $past(staged[1]));
  p_b_write_spares_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && (sel_q == SEL_B_LO || sel_q == SEL_B_HI) |=> staged[0] == $past(staged[0]));

  // R1: outputs are zero whenever reset is held
  always @(posedge clk) begin
    if (!rst_n) p_reset_zero_r1: assert (code_a == '0 && code_b == '0);
  end

endmodule

// File: tb/test_dual_dac_regif.sv
`timescale 1ns/1ps
module test_dual_dac_regif;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, load_n = 1'b1;
  logic [1:0]  sel = 2'b00;
  logic [7:0]  data = 8'h00;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] m_stage [2];
  logic [11:0] m_out   [2];

  always #2.5 clk = ~clk;

  dual_dac_regif i_dual_dac_regif (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .load_n(load_n),
    .sel(sel), .data(data), .code_a(code_a), .code_b(code_b)
  );

  // Model: the select value is {channel, upper}
  function automatic logic [11:0] model_write(logic [11:0] cur, logic upper, logic [7:0] d);
    if (upper) return (cur & 12'h0FF) | ({4'h0, d} & 12'h00F) << 8;
    else       return (cur & 12'hF00) | {4'h0, d};
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    @(negedge clk);
    check(req, code_a, m_out[0]);
    check(req, code_b, m_out[1]);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] s, logic [7:0] d, logic cs);
    @(negedge clk);
    sel = s; data = d; cs_n = cs;
    wait_cyc(2); wr_n = 1'b0;
    wait_cyc(3); wr_n = 1'b1;
    wait_cyc(4); cs_n = 1'b1;
    wait_cyc(2);
    if (!cs) m_stage[s[1]] = model_write(m_stage[s[1]], s[0], d);
  endtask

  task automatic do_load();
    @(negedge clk);
    load_n = 1'b0;
    wait_cyc(3); load_n = 1'b1;
    wait_cyc(5);
    m_out[0] = m_stage[0];
    m_out[1] = m_stage[1];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0D1A);
    m_stage[0] = '0; m_stage[1] = '0; m_out[0] = '0; m_out[1] = '0;

    // R1: reset state
    wait_cyc(3);
    check("R1", code_a, 12'h000);
    check("R1", code_b, 12'h000);
    rst_n = 1'b1;
    wait_cyc(2);
    check_outs("R1");

    // R2 R3 R4 R6: fill all four staging registers, outputs stay put
    bus_write(2'b00, 8'hA5, 1'b0); check_outs("R6");
    bus_write(2'b01, 8'h03, 1'b0); check_outs("R6");
    bus_write(2'b10, 8'h3C, 1'b0); check_outs("R6");
    bus_write(2'b11, 8'h0E, 1'b0); check_outs("R6");
    do_load();
    check("R4", code_a, 12'h3A5);
    check("R4", code_b, 12'hE3C);
    check_outs("R7");

    // R3: upper nibble of the bus byte is dropped
    bus_write(2'b01, 8'hF7, 1'b0);
    bus_write(2'b10, 8'hFF, 1'b0);
    do_load();
    check("R3", code_a, 12'h7A5);
    check("R2", code_b, 12'hEFF);

    // R5: write with chip select high is ignored
    bus_write(2'b00, 8'h11, 1'b1);
    bus_write(2'b11, 8'h02, 1'b1);
    do_load();
    check("R5", code_a, 12'h7A5);
    check("R5", code_b, 12'hEFF);

    // R9: repeated load changes nothing
    do_load();
    check_outs("R9");

    // R8: load and write edges in the same cycle
    @(negedge clk);
    sel = 2'b00; data = 8'h42; cs_n = 1'b0;
    wait_cyc(2); wr_n = 1'b0; load_n = 1'b0;
    wait_cyc(3); wr_n = 1'b1; load_n = 1'b1;
    wait_cyc(5); cs_n = 1'b1;
    m_out[0] = m_stage[0]; m_out[1] = m_stage[1];
    m_stage[0] = model_write(m_stage[0], 1'b0, 8'h42);
    check("R8", code_a, 12'h7A5);
    check_outs("R8");
    do_load();
    check("R8", code_a, 12'h742);

    // Random mix, fixed seed
    for (int i = 0; i < 60; i++) begin
      logic [1:0] rs;
      logic [7:0] rd;
      logic       rc;
      rs = 2'($urandom);
      rd = 8'($urandom);
      rc = ($urandom % 5) == 0;
      bus_write(rs, rd, rc);
      check_outs("R6");
      if (($urandom % 3) == 0) begin
        do_load();
        check_outs("R7");
      end
    end
    do_load();
    check_outs("R7");

    // R10: asynchronous reset clears staging and outputs
    bus_write(2'b01, 8'h05, 1'b0);
    bus_write(2'b11, 8'h09, 1'b0);
    #1.2 rst_n = 1'b0;
    #0.5;
    check("R10", code_a, 12'h000);
    check("R10", code_b, 12'h000);
    wait_cyc(2);
    rst_n = 1'b1;
    m_stage[0] = '0; m_stage[1] = '0; m_out[0] = '0; m_out[1] = '0;
    wait_cyc(2);
    do_load();
    check("R10", code_a, 12'h000);
    check("R10", code_b, 12'h000);

    finish_run();
  end

endmodule